// File: doc/BRIEF.md
# Descriptor-Driven Streaming DMA Engine

This block takes a 64-bit data stream, buffers it in a first-in first-out store, and writes the buffered words to system memory one beat at a time over a simple write master. A descriptor table held in a local two-port RAM says where the words go and how many to send. The host fills the table through a word-wide slave port. The engine walks the table from a current pointer and works through each valid descriptor in turn. When it finishes an entry it retires it, moves the pointer on, and can flag completion.

The producer watches a half-full output to throttle itself. While that output is low, at least half the store is free. A word presented while the store is full is dropped and sets a sticky overflow flag, which the host clears through the slave port. The completion pulse and the overflow flag are raw event sources for an interrupt block outside this one.

Top module: `stream_dma_engine`

## Requirements
- R1: A stream word is stored on every cycle in which `st_valid_i` is high and the store is not full. Stored words leave on `m_data_o` in arrival order, with none repeated and none skipped.
- R2: `st_half_full_o` is high exactly when the store holds at least FIFO_DEPTH/2 words.
- R3: A stream word presented while the store holds FIFO_DEPTH words is discarded, and `ovf_o` goes high from the next cycle on. `ovf_o` stays high until a slave write to control register 2. If a clear and a new overflow fall in the same cycle, the overflow wins.
- R4: Slave addresses with the top bit clear select the table. Address bits [IDX_W:1] give the entry and bit 0 the word. Word 0 is the destination byte address. Word 1 holds the valid flag in bit 31, the completion-flag request in bit 30, and the length in 64-bit words in bits [15:0]. Read data appears with `s_rvalid_o` one cycle after `s_rd_i`.
- R5: Slave addresses with the top bit set select control registers by bits [1:0]: 0 is the start pointer, 1 is the current pointer (read only), and 2 is the overflow flag in bit 0. Writing the start pointer also loads the current pointer when the engine is idle.
- R6: An idle engine whose current entry is valid starts on that entry in the next cycle. Beat k of the entry carries address dest + 8·k.
- R7: `m_write_o` is high only while a transfer is active and the store is not empty.
- R8: A beat is accepted when `m_write_o` is high and `m_wait_i` is low. While `m_wait_i` stalls a beat, `m_write_o`, `m_addr_o` and `m_data_o` hold.
- R9: After the last beat of an entry, the entry's valid bit is cleared and `done_irq_o` is high for one cycle if bit 30 was set. The current pointer then moves to the next entry, and from the last entry it returns to the start pointer.
- R10: An invalid entry at the current pointer leaves the engine idle, with no write issued.
- R11: An entry of length zero completes and retires without issuing any beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| st_valid_i | input | 1 | Stream word present |
| st_data_i | input | DATA_W | Stream word |
| st_half_full_o | output | 1 | Store at least half full |
| ovf_o | output | 1 | Sticky overflow flag |
| s_addr_i | input | IDX_W+2 | Slave word address |
| s_wr_i | input | 1 | Slave write strobe |
| s_rd_i | input | 1 | Slave read strobe |
| s_wdata_i | input | 32 | Slave write data |
| s_rdata_o | output | 32 | Slave read data |
| s_rvalid_o | output | 1 | Slave read data valid |
| m_write_o | output | 1 | Memory write beat request |
| m_addr_o | output | ADDR_W | Beat byte address |
| m_data_o | output | DATA_W | Beat data |
| m_wait_i | input | 1 | Memory stalls the current beat |
| done_irq_o | output | 1 | Flagged descriptor completed |

## Verification
The bench uses the full 256-word store, so overflow and the half-full boundary at 128 words are reached within a few hundred cycles. The table is cut to 4 entries so that the current pointer wraps from the last entry back to a non-zero start pointer within a short run. With those sizes, the bench exercises a zero-length entry, long entries that drain more than the buffered words while the stream refills the store, and two different stall patterns on the wait input.

// File: rtl/sdma_pkg.sv
package sdma_pkg;
  typedef enum logic [1:0] {
    ENG_IDLE = 2'd0,
    ENG_XFER = 2'd1,
    ENG_DONE = 2'd2
  } eng_state_e;

  localparam int unsigned DESC_VLD_BIT = 31;
  localparam int unsigned DESC_IRQ_BIT = 30;

  localparam logic [1:0] CTRL_START = 2'd0;
  localparam logic [1:0] CTRL_CUR   = 2'd1;
  localparam logic [1:0] CTRL_OVF   = 2'd2;
endpackage

// File: rtl/sdma_fifo.sv
module sdma_fifo #(
  parameter int unsigned DW    = 64,
  parameter int unsigned DEPTH = 256,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned LW   = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] data_i,
  input  logic          pop_i,
  output logic [DW-1:0] head_o,
  output logic [LW-1:0] level_o,
  output logic          full_o,
  output logic          empty_o,
  output logic          half_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [LW-1:0] level_q;
  logic          do_push, do_pop;

  assign full_o  = (level_q == LW'(DEPTH));
  assign empty_o = (level_q == '0);
  assign half_o  = (level_q >= LW'(DEPTH / 2));
  assign level_o = level_q;
  assign head_o  = mem_q[rd_ptr_q];

  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_ptr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      level_q  <= '0;
    end else begin
      if (do_push) wr_ptr_q <= wr_ptr_q + 1'b1;
      if (do_pop)  rd_ptr_q <= rd_ptr_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   level_q <= level_q + 1'b1;
        2'b01:   level_q <= level_q - 1'b1;
        default: level_q <= level_q;
      endcase
    end
  end
endmodule

// File: rtl/sdma_desc_ram.sv
module sdma_desc_ram #(
  parameter int unsigned N      = 16,
  parameter int unsigned LEN_W  = 16,
  parameter int unsigned ADDR_W = 32,
  localparam int unsigned IW    = $clog2(N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  // host port
  input  logic [IW-1:0]     a_idx_i,
  input  logic              a_hi_i,
  input  logic              a_we_i,
  input  logic [31:0]       a_wdata_i,
  output logic [31:0]       a_rdata_o,
  // engine port
  input  logic [IW-1:0]     b_idx_i,
  input  logic              b_clr_i,
  output logic [ADDR_W-1:0] b_dest_o,
  output logic [LEN_W-1:0]  b_len_o,
  output logic              b_vld_o,
  output logic              b_irq_o
);
  import sdma_pkg::*;

  logic [31:0] w0_q [N];
  logic [31:0] w1_q [N];

  assign a_rdata_o = a_hi_i ? w1_q[a_idx_i] : w0_q[a_idx_i];
  assign b_dest_o  = ADDR_W'(w0_q[b_idx_i]);
  assign b_len_o   = w1_q[b_idx_i][LEN_W-1:0];
  assign b_vld_o   = w1_q[b_idx_i][DESC_VLD_BIT];
  assign b_irq_o   = w1_q[b_idx_i][DESC_IRQ_BIT];

  // host write placed last: it wins a same-cycle collision on word 1
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N; i++) begin
        w0_q[i] <= '0;
        w1_q[i] <= '0;
      end
    end else begin
      if (b_clr_i) w1_q[b_idx_i][DESC_VLD_BIT] <= 1'b0;
      if (a_we_i && a_hi_i)  w1_q[a_idx_i] <= a_wdata_i;
      if (a_we_i && !a_hi_i) w0_q[a_idx_i] <= a_wdata_i;
    end
  end
endmodule

// File: rtl/sdma_engine.sv
module sdma_engine #(
  parameter int unsigned N      = 16,
  parameter int unsigned LEN_W  = 16,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned BEAT_B = 8,
  localparam int unsigned IW    = $clog2(N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] d_dest_i,
  input  logic [LEN_W-1:0]  d_len_i,
  input  logic              d_vld_i,
  input  logic              d_irq_i,
  input  logic              fifo_empty_i,
  input  logic              m_wait_i,
  input  logic              start_we_i,
  input  logic [IW-1:0]     start_wdata_i,
  output logic [IW-1:0]     start_o,
  output logic [IW-1:0]     cur_o,
  output logic              m_write_o,
  output logic [ADDR_W-1:0] m_addr_o,
  output logic              pop_o,
  output logic              clr_o,
  output logic              done_irq_o
);
  import sdma_pkg::*;

  eng_state_e        state_q;
  logic [IW-1:0]     start_q, cur_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  rem_q;
  logic              irq_q;
  logic              beat;

  assign m_write_o  = (state_q == ENG_XFER) && !fifo_empty_i;
  assign m_addr_o   = addr_q;
  assign beat       = m_write_o && !m_wait_i;
  assign pop_o      = beat;
  assign clr_o      = (state_q == ENG_DONE);
  assign done_irq_o = (state_q == ENG_DONE) && irq_q;
  assign start_o    = start_q;
  assign cur_o      = cur_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ENG_IDLE;
      start_q <= '0;
      cur_q   <= '0;
      addr_q  <= '0;
      rem_q   <= '0;
      irq_q   <= 1'b0;
    end else begin
      case (state_q)
        ENG_IDLE: begin
          if (d_vld_i) begin
            addr_q  <= d_dest_i;
            rem_q   <= d_len_i;
            irq_q   <= d_irq_i;
            state_q <= (d_len_i == '0) ? ENG_DONE : ENG_XFER;
          end
        end
        ENG_XFER: begin
          if (beat) begin
            addr_q <= addr_q + ADDR_W'(BEAT_B);
            rem_q  <= rem_q - 1'b1;
            if (rem_q == LEN_W'(1)) state_q <= ENG_DONE;
          end
        end
        ENG_DONE: begin
          cur_q   <= (cur_q == IW'(N - 1)) ? start_q : cur_q + 1'b1;
          state_q <= ENG_IDLE;
        end
        default: state_q <= ENG_IDLE;
      endcase
      if (start_we_i) begin
        start_q <= start_wdata_i;
        if (state_q == ENG_IDLE) cur_q <= start_wdata_i;
      end
    end
  end
endmodule

// File: rtl/stream_dma_engine.sv
module stream_dma_engine #(
  parameter int unsigned DATA_W     = 64,
  parameter int unsigned FIFO_DEPTH = 256,
  parameter int unsigned DESC_N     = 16,
  parameter int unsigned LEN_W      = 16,
  parameter int unsigned ADDR_W     = 32,
  localparam int unsigned IDX_W     = $clog2(DESC_N),
  localparam int unsigned SAW       = IDX_W + 2,
  localparam int unsigned LVL_W     = $clog2(FIFO_DEPTH) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              st_valid_i,
  input  logic [DATA_W-1:0] st_data_i,
  output logic              st_half_full_o,
  output logic              ovf_o,
  input  logic [SAW-1:0]    s_addr_i,
  input  logic              s_wr_i,
  input  logic              s_rd_i,
  input  logic [31:0]       s_wdata_i,
  output logic [31:0]       s_rdata_o,
  output logic              s_rvalid_o,
  output logic              m_write_o,
  output logic [ADDR_W-1:0] m_addr_o,
  output logic [DATA_W-1:0] m_data_o,
  input  logic              m_wait_i,
  output logic              done_irq_o
);
  import sdma_pkg::*;

  localparam int unsigned BEAT_B = DATA_W / 8;

  logic              fifo_full, fifo_empty, fifo_pop;
  logic [LVL_W-1:0]  fifo_level;
  logic              ctrl_sel, ovf_q, ovf_set, ovf_clr, start_we;
  logic [31:0]       ram_rdata, rd_mux, rdata_q;
  logic              rvalid_q;
  logic [ADDR_W-1:0] d_dest;
  logic [LEN_W-1:0]  d_len;
  logic              d_vld, d_irq, d_clr;
  logic [IDX_W-1:0]  start_ptr, cur_ptr;

  assign ctrl_sel = s_addr_i[SAW-1];
  assign start_we = s_wr_i && ctrl_sel && (s_addr_i[1:0] == CTRL_START);
  assign ovf_clr  = s_wr_i && ctrl_sel && (s_addr_i[1:0] == CTRL_OVF);
  assign ovf_set  = st_valid_i && fifo_full;

  sdma_fifo #(.DW(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (st_valid_i),
    .data_i  (st_data_i),
    .pop_i   (fifo_pop),
    .head_o  (m_data_o),
    .level_o (fifo_level),
    .full_o  (fifo_full),
    .empty_o (fifo_empty),
    .half_o  (st_half_full_o)
  );

  sdma_desc_ram #(.N(DESC_N), .LEN_W(LEN_W), .ADDR_W(ADDR_W)) u_ram (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .a_idx_i   (s_addr_i[IDX_W:1]),
    .a_hi_i    (s_addr_i[0]),
    .a_we_i    (s_wr_i && !ctrl_sel),
    .a_wdata_i (s_wdata_i),
    .a_rdata_o (ram_rdata),
    .b_idx_i   (cur_ptr),
    .b_clr_i   (d_clr),
    .b_dest_o  (d_dest),
    .b_len_o   (d_len),
    .b_vld_o   (d_vld),
    .b_irq_o   (d_irq)
  );

  sdma_engine #(.N(DESC_N), .LEN_W(LEN_W), .ADDR_W(ADDR_W), .BEAT_B(BEAT_B)) u_eng (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .d_dest_i      (d_dest),
    .d_len_i       (d_len),
    .d_vld_i       (d_vld),
    .d_irq_i       (d_irq),
    .fifo_empty_i  (fifo_empty),
    .m_wait_i      (m_wait_i),
    .start_we_i    (start_we),
    .start_wdata_i (s_wdata_i[IDX_W-1:0]),
    .start_o       (start_ptr),
    .cur_o         (cur_ptr),
    .m_write_o     (m_write_o),
    .m_addr_o      (m_addr_o),
    .pop_o         (fifo_pop),
    .clr_o         (d_clr),
    .done_irq_o    (done_irq_o)
  );

  always_comb begin
    rd_mux = ram_rdata;
    if (ctrl_sel) begin
      case (s_addr_i[1:0])
        CTRL_START: rd_mux = 32'(start_ptr);
        CTRL_CUR:   rd_mux = 32'(cur_ptr);
        CTRL_OVF:   rd_mux = {31'b0, ovf_q};
        default:    rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovf_q    <= 1'b0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      if (ovf_set)      ovf_q <= 1'b1;
      else if (ovf_clr) ovf_q <= 1'b0;
      rvalid_q <= s_rd_i;
      if (s_rd_i) rdata_q <= rd_mux;
    end
  end

  assign ovf_o      = ovf_q;
  assign s_rdata_o  = rdata_q;
  assign s_rvalid_o = rvalid_q;
endmodule

// File: rtl/sdma_checker.sv
module sdma_checker #(
  parameter int unsigned DATA_W     = 64,
  parameter int unsigned FIFO_DEPTH = 256,
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned LVL_W      = 9
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              st_valid_i,
  input logic              st_half_full_o,
  input logic              ovf_o,
  input logic              ovf_clr,
  input logic [LVL_W-1:0]  fifo_level,
  input logic              s_rd_i,
  input logic              s_rvalid_o,
  input logic              m_write_o,
  input logic              m_wait_i,
  input logic [ADDR_W-1:0] m_addr_o,
  input logic [DATA_W-1:0] m_data_o,
  input logic              done_irq_o
);
  p_level_bound_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_level <= LVL_W'(FIFO_DEPTH));

  p_free_space_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !st_half_full_o |-> (fifo_level < LVL_W'(FIFO_DEPTH / 2)));

  p_ovf_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_valid_i && fifo_level == LVL_W'(FIFO_DEPTH)) |=> ovf_o);

  p_ovf_sticky_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && !ovf_clr) |=> ovf_o);

  p_rvalid_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_rd_i |=> s_rvalid_o);

  p_write_nonempty_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_write_o |-> (fifo_level != '0));

  p_stall_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_write_o && m_wait_i) |=> (m_write_o && $stable(m_addr_o) && $stable(m_data_o)));

  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_irq_o |=> !done_irq_o);
endmodule

bind stream_dma_engine sdma_checker #(
  .DATA_W(DATA_W), .FIFO_DEPTH(FIFO_DEPTH), .ADDR_W(ADDR_W), .LVL_W(LVL_W)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .st_valid_i     (st_valid_i),
  .st_half_full_o (st_half_full_o),
  .ovf_o          (ovf_o),
  .ovf_clr        (ovf_clr),
  .fifo_level     (fifo_level),
  .s_rd_i         (s_rd_i),
  .s_rvalid_o     (s_rvalid_o),
  .m_write_o      (m_write_o),
  .m_wait_i       (m_wait_i),
  .m_addr_o       (m_addr_o),
  .m_data_o       (m_data_o),
  .done_irq_o     (done_irq_o)
);

// File: tb/tb_stream_dma_engine.sv
module tb_stream_dma_engine;
  localparam int CLK_PERIOD = 20;
  localparam int DEPTH  = 256;
  localparam int NDESC  = 4;
  localparam int IW     = 2;
  localparam int SAW    = IW + 2;
  localparam int WD_MAX = 20000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic st_valid = 1'b0;
  logic [63:0] st_data = '0;
  logic st_half, ovf;
  logic [SAW-1:0] s_addr = '0;
  logic s_wr = 1'b0, s_rd = 1'b0;
  logic [31:0] s_wdata = '0, s_rdata;
  logic s_rvalid;
  logic m_write, m_wait = 1'b0, done_irq;
  logic [31:0] m_addr;
  logic [63:0] m_data;

  always #(CLK_PERIOD / 2) clk = ~clk;

  stream_dma_engine #(.DATA_W(64), .FIFO_DEPTH(DEPTH), .DESC_N(NDESC), .LEN_W(16), .ADDR_W(32)) dut (
    .clk_i(clk), .rst_ni(rst_n), .st_valid_i(st_valid), .st_data_i(st_data),
    .st_half_full_o(st_half), .ovf_o(ovf), .s_addr_i(s_addr), .s_wr_i(s_wr),
    .s_rd_i(s_rd), .s_wdata_i(s_wdata), .s_rdata_o(s_rdata), .s_rvalid_o(s_rvalid),
    .m_write_o(m_write), .m_addr_o(m_addr), .m_data_o(m_data), .m_wait_i(m_wait),
    .done_irq_o(done_irq)
  );

  int checks = 0, fails = 0, cyc = 0;
  bit finished = 1'b0;

  // reference model state
  logic [63:0] q[$];
  logic [31:0] d_w0 [NDESC];
  logic [31:0] d_w1 [NDESC];
  int  e_st = 0;          // 0 idle, 1 transfer, 2 done
  logic [31:0] e_addr;
  int  e_rem = 0;
  bit  e_irq = 0, m_ovf = 0;
  int  m_start = 0, m_cur = 0;
  bit  x_rv = 0;
  logic [31:0] x_rd = '0;

  bit  stream_on = 0;
  int  wait_mode = 0;
  logic [31:0] seq = '0;
  int  beats = 0, dones = 0;
  bit  prev_stall = 0;
  logic [31:0] prev_addr;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  function automatic logic [31:0] slave_val(input logic [SAW-1:0] a);
    if (a[SAW-1]) begin
      case (a[1:0])
        2'd0: return 32'(m_start);
        2'd1: return 32'(m_cur);
        2'd2: return {31'b0, m_ovf};
        default: return '0;
      endcase
    end
    return a[0] ? d_w1[a[IW:1]] : d_w0[a[IW:1]];
  endfunction

  // one clock: inputs already set; compare, advance model, cross the edge
  task automatic step();
    bit xw, pop, push, oset, oclr, swe, ctl;
    int sz;
    st_valid = stream_on;
    st_data  = {~seq, seq};
    case (wait_mode)
      1: m_wait = cyc[0];
      2: m_wait = (cyc % 3) != 0;
      default: m_wait = 1'b0;
    endcase
    #1;
    sz = q.size();
    xw = (e_st == 1) && (sz > 0);
    chk(st_half == (sz >= DEPTH / 2), "R2", "half_full", 64'(st_half), 64'(sz >= DEPTH / 2));
    chk(ovf == m_ovf, "R3", "ovf", 64'(ovf), 64'(m_ovf));
    chk(m_write == xw, "R7", "m_write", 64'(m_write), 64'(xw));
    if (xw) begin
      chk(m_addr == e_addr, "R6", "m_addr", 64'(m_addr), 64'(e_addr));
      chk(m_data == q[0], "R1", "m_data", m_data, q[0]);
    end
    if (prev_stall)
      chk(m_write && m_addr == prev_addr, "R8", "stalled beat held", 64'(m_addr), 64'(prev_addr));
    chk(done_irq == (e_st == 2 && e_irq), "R9", "done_irq", 64'(done_irq), 64'(e_st == 2 && e_irq));
    chk(s_rvalid == x_rv, "R4", "rvalid", 64'(s_rvalid), 64'(x_rv));
    if (x_rv) chk(s_rdata == x_rd, "R4", "rdata", 64'(s_rdata), 64'(x_rd));
    prev_stall = xw && m_wait;
    prev_addr  = e_addr;
    // model update
    pop  = xw && !m_wait;
    push = stream_on && (sz < DEPTH);
    oset = stream_on && (sz == DEPTH);
    ctl  = s_addr[SAW-1];
    oclr = s_wr && ctl && s_addr[1:0] == 2'd2;
    swe  = s_wr && ctl && s_addr[1:0] == 2'd0;
    x_rv = s_rd;
    if (s_rd) x_rd = slave_val(s_addr);
    if (pop) beats++;
    case (e_st)
      0: if (d_w1[m_cur][31]) begin
           e_addr = d_w0[m_cur];
           e_rem  = int'(d_w1[m_cur][15:0]);
           e_irq  = d_w1[m_cur][30];
           e_st   = (e_rem == 0) ? 2 : 1;
           if (swe) m_cur = int'(s_wdata[IW-1:0]);
         end else if (swe) m_cur = int'(s_wdata[IW-1:0]);
      1: if (pop) begin
           e_addr = e_addr + 32'd8;
           if (e_rem == 1) e_st = 2;
           e_rem--;
         end
      default: begin
        d_w1[m_cur][31] = 1'b0;
        m_cur = (m_cur == NDESC - 1) ? m_start : m_cur + 1;
        e_st = 0;
        dones++;
      end
    endcase
    if (swe) m_start = int'(s_wdata[IW-1:0]);
    if (s_wr && !ctl) begin
      if (s_addr[0]) d_w1[s_addr[IW:1]] = s_wdata;
      else           d_w0[s_addr[IW:1]] = s_wdata;
    end
    if (oset) m_ovf = 1'b1;
    else if (oclr) m_ovf = 1'b0;
    if (pop) void'(q.pop_front());
    if (push) q.push_back(st_data);
    if (stream_on) seq++;
    @(posedge clk);
    @(negedge clk);
    cyc++;
    s_wr = 1'b0;
    s_rd = 1'b0;
  endtask

  task automatic slv_wr(input logic [SAW-1:0] a, input logic [31:0] d);
    s_addr = a; s_wdata = d; s_wr = 1'b1;
    step();
  endtask

  task automatic slv_rd(input logic [SAW-1:0] a, input logic [31:0] exp, input string req);
    s_addr = a; s_rd = 1'b1;
    step();
    chk(s_rvalid && s_rdata == exp, req, "slave readback", 64'(s_rdata), 64'(exp));
  endtask

  function automatic logic [SAW-1:0] tab(input int idx, input int hi);
    return {1'b0, IW'(idx), 1'(hi)};
  endfunction

  function automatic logic [SAW-1:0] ctl(input int r);
    return SAW'({1'b1, {(SAW - 3){1'b0}}, 2'(r)});
  endfunction

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  always @(posedge clk) begin
    if (!finished && cyc > WD_MAX) begin
      finished = 1'b1;
      fails++;
      $display("FAIL watchdog expired act=%0d exp<=%0d", cyc, WD_MAX);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int wr_seen, d0;
    for (int i = 0; i < NDESC; i++) begin d_w0[i] = '0; d_w1[i] = '0; end
    repeat (3) @(negedge clk);
    // R1 R2 R3 R7 R9: reset state
    chk(!st_half && !ovf && !m_write && !done_irq && !s_rvalid, "R1",
        "reset outputs", {st_half, ovf, m_write, done_irq, s_rvalid}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R4 R5: table and control access
    slv_wr(tab(0, 0), 32'h0000_1000);
    slv_rd(tab(0, 0), 32'h0000_1000, "R4");
    slv_rd(ctl(0), 32'd0, "R5");

    // R10 R2 R3: stream with no valid entry until overflow
    stream_on = 1;
    wr_seen = 0;
    for (int i = 0; i < 300; i++) begin step(); if (m_write) wr_seen++; end
    stream_on = 0;
    chk(wr_seen == 0, "R10", "writes while idle", 64'(wr_seen), 64'd0);
    chk(st_half && ovf, "R3", "full store flags", {st_half, ovf}, 64'd3);
    slv_rd(ctl(2), 32'd1, "R3");
    slv_wr(ctl(2), 32'd0);
    slv_rd(ctl(2), 32'd0, "R3");

    // R6 R8 R9: flagged entry with alternating stalls
    wait_mode = 1;
    slv_wr(tab(1, 0), 32'h0000_2000);
    slv_wr(tab(1, 1), 32'h8000_0000);          // length zero, R11
    slv_wr(tab(2, 0), 32'h0001_0000);
    slv_wr(tab(2, 1), 32'h8000_00C8);          // 200 words, no flag
    slv_wr(tab(3, 0), 32'h0003_0000);
    slv_wr(tab(3, 1), 32'hC000_0005);          // 5 words, flagged
    d0 = dones;
    slv_wr(tab(0, 1), 32'hC000_0064);          // 100 words, flagged
    run(260);
    slv_rd(tab(0, 1), 32'h4000_0064, "R9");    // valid bit retired
    wait_mode = 2;
    stream_on = 1;
    run(900);
    stream_on = 0;
    run(40);
    chk(dones - d0 == 4, "R11", "entries retired", 64'(dones - d0), 64'd4);
    slv_rd(tab(1, 1), 32'h0000_0000, "R11");
    slv_rd(ctl(1), 32'd0, "R9");               // wrapped to start 0

    // R5 R9: wrap to a non-zero start pointer
    wait_mode = 0;
    slv_wr(ctl(0), 32'd2);
    slv_rd(ctl(1), 32'd2, "R5");
    slv_wr(tab(3, 1), 32'h8000_0002);
    slv_wr(tab(2, 0), 32'h0005_0000);
    slv_wr(tab(2, 1), 32'hC000_0001);
    run(30);
    slv_rd(ctl(1), 32'd2, "R9");
    slv_rd(ctl(0), 32'd2, "R5");

    // R1: drain leftover words via one more entry
    stream_on = 1;
    slv_wr(tab(2, 1), 32'h8000_0010);
    run(40);
    stream_on = 0;
    run(10);

    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule